// File: doc/BRIEF.md
# Byte-Wide Memory Coefficient Loader

This block fills a filter's coefficient storage from an external memory that is one byte wide. On a start request it drives the memory address bus itself and walks through a run of bytes. It joins each pair of bytes into a 16-bit coefficient and writes that word into the coefficient RAM. No host takes part in the transfer. One request loads the whole coefficient set, and a busy flag stays high from the first address to the last RAM write.

Up to sixteen filter devices can share one memory. Each device reads only its own region, which is chosen by a 4-bit device index taken when the load starts. The region base is the index times the size of one coefficient set in bytes. Because the set size is a power of two, the memory address is the index placed above a byte offset. A parameter sets how many wait cycles follow each address change before the byte is sampled, so the loader can run against slow memories.

Top module: `cl_eprom_loader`

## Requirements
- R1: After reset, busy_o is low and coef_we_o is low, and both stay low until a start request is seen.
- R2: A high start_i sampled while idle begins a transfer. busy_o is high from the next cycle for exactly 2·N_COEF·(WAIT_CYC+1)+1 cycles.
- R3: During a transfer, mem_addr_o is {device index, byte offset}. The device index occupies the top 4 bits, and the offset counts up by one from 0 to 2·N_COEF−1.
- R4: Each memory address is held for WAIT_CYC+1 cycles. The byte is sampled on the last clock edge of that window.
- R5: The byte at an even offset is the low half of a coefficient and the byte at the next odd offset is the high half. The written word is {high, low}.
- R6: Exactly N_COEF single-cycle writes occur per transfer. Coefficient k is written at coef_addr_o = k, in ascending order.
- R7: A start request while busy_o is high is ignored. The transfer in progress continues unchanged.
- R8: The device index is sampled only when a transfer starts. Changing dev_idx_i during a transfer has no effect on the addresses.
- R9: Asserting rst_n during a transfer aborts it at once: busy_o and coef_we_o go low. A later start performs a complete, correct load.
- R10: The final coefficient write happens while busy_o is still high, and busy_o falls in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Load request, sampled while idle |
| dev_idx_i | input | DEV_IDX_W (4) | Device index selecting the memory region |
| mem_addr_o | output | DEV_IDX_W+$clog2(N_COEF)+1 | Byte address to the external memory |
| mem_data_i | input | 8 | Byte read from the external memory |
| busy_o | output | 1 | High for the whole transfer |
| coef_we_o | output | 1 | Coefficient RAM write strobe |
| coef_addr_o | output | $clog2(N_COEF) | Coefficient RAM write address |
| coef_data_o | output | COEF_W (16) | Coefficient RAM write data |

## Verification
The hardest case to reach is the sampling moment: a loader that samples one cycle early still produces plausible-looking words. The bench memory model therefore returns a byte only after WAIT_CYC clock edges of latency, so an early sample picks up the byte of the previous address and fails the scoreboard. The tests that check what is ignored also need attention. The bench fires a second start with a different device index in the middle of a load and still expects the original region's words. Reset is applied asynchronously partway through a load, and the bench then runs a clean load after it.

// File: rtl/cl_pkg.sv
package cl_pkg;
  typedef enum logic [1:0] {
    LD_IDLE   = 2'd0,
    LD_ACCESS = 2'd1,
    LD_FINISH = 2'd2
  } ld_state_e;
endpackage

// File: rtl/cl_wait_timer.sv
module cl_wait_timer #(
  parameter int WAIT_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic run_i,
  output logic done_o
);
  localparam int CW = (WAIT_CYC < 1) ? 1 : $clog2(WAIT_CYC + 1);

  generate
    if (WAIT_CYC == 0) begin : g_nowait
      assign done_o = run_i && !clr_i;
    end else begin : g_wait
      logic [CW-1:0] cnt_q, cnt_d;

      assign done_o = run_i && !clr_i && (cnt_q == CW'(WAIT_CYC));

      always_comb begin
        cnt_d = cnt_q;
        if (clr_i)       cnt_d = '0;
        else if (done_o) cnt_d = '0;
        else if (run_i)  cnt_d = cnt_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
      end

      // R4
      done_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    end
  endgenerate
endmodule

// File: rtl/cl_addr_gen.sv
module cl_addr_gen #(
  parameter int DEV_IDX_W = 4,
  parameter int BYTE_W    = 5
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        load_i,
  input  logic [DEV_IDX_W-1:0]        idx_i,
  input  logic                        step_i,
  output logic [DEV_IDX_W+BYTE_W-1:0] mem_addr_o,
  output logic                        last_o,
  output logic                        odd_o,
  output logic [BYTE_W-2:0]           word_o
);
  logic [DEV_IDX_W-1:0] idx_q, idx_d;
  logic [BYTE_W-1:0]    off_q, off_d;

  always_comb begin
    idx_d = idx_q;
    off_d = off_q;
    if (load_i) begin
      idx_d = idx_i;
      off_d = '0;
    end else if (step_i) begin
      off_d = off_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      off_q <= '0;
    end else begin
      idx_q <= idx_d;
      off_q <= off_d;
    end
  end

  assign mem_addr_o = {idx_q, off_q};
  assign last_o     = &off_q;
  assign odd_o      = off_q[0];
  assign word_o     = off_q[BYTE_W-1:1];

  // R4
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_i && !load_i) |=> $stable(mem_addr_o));
endmodule

// File: rtl/cl_byte_pack.sv
module cl_byte_pack #(
  parameter int CA_W   = 4,
  parameter int COEF_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_i,
  input  logic              odd_i,
  input  logic [CA_W-1:0]   word_i,
  input  logic [7:0]        byte_i,
  output logic              we_o,
  output logic [CA_W-1:0]   waddr_o,
  output logic [COEF_W-1:0] wdata_o
);
  localparam int LO_W = COEF_W / 2;

  logic [LO_W-1:0]   lo_q, lo_d;
  logic              we_d;
  logic [CA_W-1:0]   waddr_d;
  logic [COEF_W-1:0] wdata_d;

  always_comb begin
    lo_d    = lo_q;
    we_d    = 1'b0;
    waddr_d = waddr_o;
    wdata_d = wdata_o;
    if (take_i && !odd_i) begin
      lo_d = byte_i;
    end else if (take_i && odd_i) begin
      we_d    = 1'b1;
      waddr_d = word_i;
      wdata_d = {byte_i, lo_q};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q    <= '0;
      we_o    <= 1'b0;
      waddr_o <= '0;
      wdata_o <= '0;
    end else begin
      lo_q    <= lo_d;
      we_o    <= we_d;
      waddr_o <= waddr_d;
      wdata_o <= wdata_d;
    end
  end

  // R6
  we_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we_o |=> !we_o);
endmodule

// File: rtl/cl_eprom_loader.sv
module cl_eprom_loader
  import cl_pkg::*;
#(
  parameter int N_COEF    = 16,
  parameter int COEF_W    = 16,
  parameter int DEV_IDX_W = 4,
  parameter int WAIT_CYC  = 3,
  localparam int CA_W     = $clog2(N_COEF),
  localparam int BYTE_W   = CA_W + 1,
  localparam int MEM_AW   = DEV_IDX_W + BYTE_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic [DEV_IDX_W-1:0] dev_idx_i,
  output logic [MEM_AW-1:0]    mem_addr_o,
  input  logic [7:0]           mem_data_i,
  output logic                 busy_o,
  output logic                 coef_we_o,
  output logic [CA_W-1:0]      coef_addr_o,
  output logic [COEF_W-1:0]    coef_data_o
);
  logic rst_meta_q, rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_s      <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_s      <= rst_meta_q;
    end
  end

  ld_state_e         state_q, state_d;
  logic              load, adv, last, odd, run;
  logic [CA_W-1:0]   word;

  always_comb begin
    state_d = state_q;
    load    = 1'b0;
    unique case (state_q)
      LD_IDLE: begin
        if (start_i) begin
          load    = 1'b1;
          state_d = LD_ACCESS;
        end
      end
      LD_ACCESS: begin
        if (adv && last) state_d = LD_FINISH;
      end
      LD_FINISH: state_d = LD_IDLE;
      default:   state_d = LD_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) state_q <= LD_IDLE;
    else        state_q <= state_d;
  end

  assign run    = (state_q == LD_ACCESS);
  assign busy_o = (state_q != LD_IDLE);

  cl_wait_timer #(.WAIT_CYC(WAIT_CYC)) u_timer (
    .clk    (clk),
    .rst_n  (rst_s),
    .clr_i  (load),
    .run_i  (run),
    .done_o (adv)
  );

  cl_addr_gen #(.DEV_IDX_W(DEV_IDX_W), .BYTE_W(BYTE_W)) u_addr (
    .clk        (clk),
    .rst_n      (rst_s),
    .load_i     (load),
    .idx_i      (dev_idx_i),
    .step_i     (adv && !last),
    .mem_addr_o (mem_addr_o),
    .last_o     (last),
    .odd_o      (odd),
    .word_o     (word)
  );

  cl_byte_pack #(.CA_W(CA_W), .COEF_W(COEF_W)) u_pack (
    .clk     (clk),
    .rst_n   (rst_s),
    .take_i  (adv),
    .odd_i   (odd),
    .word_i  (word),
    .byte_i  (mem_data_i),
    .we_o    (coef_we_o),
    .waddr_o (coef_addr_o),
    .wdata_o (coef_data_o)
  );

  // R10
  we_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_s)
    coef_we_o |-> busy_o);

  // R8
  region_stable_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (busy_o && $past(busy_o)) |-> $stable(mem_addr_o[MEM_AW-1 -: DEV_IDX_W]));

  // R1
  idle_no_write_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (!busy_o && $past(!busy_o)) |-> !coef_we_o);
endmodule

// File: tb/sim_cl_eprom_loader.sv
module sim_cl_eprom_loader;
  localparam int N     = 16;
  localparam int W     = 3;
  localparam int CA_W  = $clog2(N);
  localparam int AW    = 4 + CA_W + 1;
  localparam int XFER  = 2 * N * (W + 1) + 1;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start_i = 1'b0;
  logic [3:0]      dev_idx_i = '0;
  logic [AW-1:0]   mem_addr_o;
  logic [7:0]      mem_data_i;
  logic            busy_o, coef_we_o;
  logic [CA_W-1:0] coef_addr_o;
  logic [15:0]     coef_data_o;

  always #2 clk = ~clk;

  cl_eprom_loader #(.N_COEF(N), .WAIT_CYC(W)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .dev_idx_i(dev_idx_i),
    .mem_addr_o(mem_addr_o), .mem_data_i(mem_data_i), .busy_o(busy_o),
    .coef_we_o(coef_we_o), .coef_addr_o(coef_addr_o), .coef_data_o(coef_data_o)
  );

  function automatic logic [7:0] mem_byte(input logic [AW-1:0] a);
    logic [7:0] t;
    t = a[7:0] * 8'd37;
    return t ^ {7'h2B, a[AW-1]};
  endfunction

  // memory with W edges of latency
  logic [7:0] p0, p1, p2;
  always @(posedge clk) begin
    p0 <= mem_byte(mem_addr_o);
    p1 <= p0;
    p2 <= p1;
  end
  assign mem_data_i = p2;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  bit ignore_wr = 1'b0;
  int wr_cnt  = 0;
  logic [3:0] exp_idx;

  typedef struct packed { logic [CA_W-1:0] a; logic [15:0] d; } item_t;
  item_t exp_q[$];

  task automatic chk(input bit ok, input string req, input string msg);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s", req, msg);
    end
  endtask

  // scoreboard monitor
  logic [AW-1:0] prev_addr;
  int  hold;
  bit  was_busy = 1'b0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (coef_we_o && !ignore_wr) begin
        item_t e;
        wr_cnt++;
        chk(busy_o, "R10", $sformatf("busy act=%0b exp=1 at write", busy_o));
        if (exp_q.size() == 0) begin
          chk(1'b0, "R6", $sformatf("extra write addr act=%0d exp=none", coef_addr_o));
        end else begin
          e = exp_q.pop_front();
          chk(coef_addr_o == e.a, "R6",
              $sformatf("addr act=%0d exp=%0d", coef_addr_o, e.a));
          chk(coef_data_o == e.d, "R5",
              $sformatf("data act=%h exp=%h", coef_data_o, e.d));
        end
      end
      if (busy_o && !ignore_wr) begin
        if (!was_busy) begin
          prev_addr = mem_addr_o;
          hold = 1;
          chk(mem_addr_o == {exp_idx, 5'd0}, "R3",
              $sformatf("first addr act=%h exp=%h", mem_addr_o, {exp_idx, 5'd0}));
        end else if (mem_addr_o != prev_addr) begin
          chk(hold == W + 1, "R4", $sformatf("hold act=%0d exp=%0d", hold, W + 1));
          chk(mem_addr_o == prev_addr + 1'b1 && mem_addr_o[AW-1 -: 4] == exp_idx, "R3",
              $sformatf("addr act=%h exp=%h", mem_addr_o, prev_addr + 1'b1));
          prev_addr = mem_addr_o;
          hold = 1;
        end else begin
          hold++;
        end
      end
      was_busy = busy_o;
    end else begin
      was_busy = 1'b0;
    end
  end

  task automatic push_set(input logic [3:0] idx);
    for (int k = 0; k < N; k++) begin
      item_t e;
      logic [AW-1:0] base;
      base = {idx, 5'd0} + AW'(2 * k);
      e.a = CA_W'(k);
      e.d = {mem_byte(base + 1'b1), mem_byte(base)};
      exp_q.push_back(e);
    end
  endtask

  // driver: returns measured busy length
  task automatic run_load(input logic [3:0] idx, input bit disturb, output int blen);
    exp_idx = idx;
    push_set(idx);
    wr_cnt = 0;
    @(negedge clk);
    dev_idx_i = idx;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    blen = 0;
    while (busy_o) begin
      blen++;
      if (disturb && blen == 37) begin
        start_i = 1'b1;               // R7: request while busy
        dev_idx_i = ~idx;             // R8: index change while busy
      end
      if (disturb && blen == 39) start_i = 1'b0;
      @(negedge clk);
      if (blen > 4 * XFER) break;
    end
    start_i = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      done = 1'b1;
      chk(1'b0, "watchdog", "act=timeout exp=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int blen;
    repeat (3) @(negedge clk);
    chk(busy_o == 1'b0 && coef_we_o == 1'b0, "R1",
        $sformatf("in reset busy/we act=%0b%0b exp=00", busy_o, coef_we_o));
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(busy_o == 1'b0 && coef_we_o == 1'b0, "R1",
        $sformatf("after reset busy/we act=%0b%0b exp=00", busy_o, coef_we_o));

    // R2 R3 R5 R6: device 0
    run_load(4'd0, 1'b0, blen);
    chk(blen == XFER, "R2", $sformatf("busy length act=%0d exp=%0d", blen, XFER));
    chk(wr_cnt == N, "R6", $sformatf("writes act=%0d exp=%0d", wr_cnt, N));
    chk(exp_q.size() == 0, "R6", $sformatf("left act=%0d exp=0", exp_q.size()));

    // upper boundary device 15
    run_load(4'd15, 1'b0, blen);
    chk(blen == XFER, "R2", $sformatf("busy length dev15 act=%0d exp=%0d", blen, XFER));
    chk(wr_cnt == N, "R6", $sformatf("writes dev15 act=%0d exp=%0d", wr_cnt, N));

    // R7 R8: disturbances during device 5 load
    run_load(4'd5, 1'b1, blen);
    chk(blen == XFER, "R7", $sformatf("busy length disturbed act=%0d exp=%0d", blen, XFER));
    chk(wr_cnt == N && exp_q.size() == 0, "R8",
        $sformatf("writes disturbed act=%0d exp=%0d", wr_cnt, N));
    repeat (3) @(negedge clk);
    chk(busy_o == 1'b0, "R7", $sformatf("busy after load act=%0b exp=0", busy_o));

    // R9: abort with async reset
    ignore_wr = 1'b1;
    @(negedge clk);
    dev_idx_i = 4'd9;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (50) @(negedge clk);
    #1 rst_n = 1'b0;
    #0.5;
    chk(busy_o == 1'b0 && coef_we_o == 1'b0, "R9",
        $sformatf("abort busy/we act=%0b%0b exp=00", busy_o, coef_we_o));
    @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    ignore_wr = 1'b0;
    chk(busy_o == 1'b0, "R9", $sformatf("idle after abort act=%0b exp=0", busy_o));
    run_load(4'd10, 1'b0, blen);
    chk(blen == XFER && wr_cnt == N, "R9",
        $sformatf("reload len/writes act=%0d/%0d exp=%0d/%0d", blen, wr_cnt, XFER, N));

    repeat (4) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule